// File: doc/BRIEF.md
# Serial converter conversion sequencer

This block runs the master side of a 12-bit successive-approximation converter that has a serial output. The converter is controlled by an active-low convert-start strobe, reports a busy flag, and is read with sixteen serial clocks. A one-cycle request in the idle state starts one sample. The block drives the strobe and waits for busy to fall. It then clocks sixteen bits in, most significant first. The twelve result bits appear on a parallel output, marked by a one-cycle valid pulse.

Two run modes are chosen per request. In fast mode the strobe drops for a short pulse and is back high long before the conversion ends, so the converter stays powered. In sleep mode the strobe is held low through the end of conversion so that the converter powers down. The next request raises the strobe to wake the converter, waits out the wake-up time, and then drops the strobe to start the conversion. After every read or abort the block keeps a quiet window before it accepts a new request. This gives the track/hold time to settle before the next falling edge of the strobe. A busy-timeout limit aborts a conversion that never completes.

Top module: `adc_seq`

## Requirements
- R1: While reset is asserted, and directly after it, the strobe is high, the serial clock is low, and valid and timeout are low.
- R2: A fast-mode request in idle, with the strobe high, drives the strobe low for exactly STROBE_LOW cycles and then high. The strobe stays high while busy is awaited and during the read.
- R3: A sleep-mode request, or any request made while the strobe idles low after a sleep-mode sample, first holds the strobe high for WAKE_CYC cycles and then drives it low. In sleep mode the strobe then stays low through the read and the following idle period, until the next request. A fast-mode request made from this low-idle state gives a STROBE_LOW pulse after the wake window.
- R4: End of conversion is taken only from a falling edge of busy (high at one clock edge, low at the next) while the block waits for it. The serial clock starts high at the next cycle and gives exactly 16 pulses. Each pulse is SCLK_HALF cycles high and SCLK_HALF cycles low.
- R5: Serial data is sampled at each falling edge of the serial clock, most significant bit first. The data output holds the last 12 of the 16 bits, so the first four bits are ignored whatever their value.
- R6: Valid is a single-cycle pulse. It is asserted in the cycle after the sixteenth falling sample, and the data output holds its value until the next valid.
- R7: After a read or a timeout, QUIET_CYC cycles pass before a request is accepted. Requests made during that window are ignored, and the strobe does not move.
- R8: Requests made while a sample is in progress are ignored and do not cause a second sample.
- R9: If busy does not fall within timeout_lim_i+1 cycles of waiting, timeout pulses for one cycle. No serial clocks and no valid are produced, and the block passes through the quiet window.
- R10: The mode is sampled when the request is accepted. Changing sleep_mode_i during a sample has no effect on that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Sample request, accepted only in idle |
| sleep_mode_i | input | 1 | 1 selects sleep mode, 0 selects fast mode |
| timeout_lim_i | input | TMO_W | Busy wait limit in cycles, minus one |
| busy_i | input | 1 | Busy flag from the converter |
| sdata_i | input | 1 | Serial data from the converter |
| convst_n_o | output | 1 | Active-low convert-start strobe |
| sclk_o | output | 1 | Serial read clock |
| data_o | output | 12 | Last captured result |
| valid_o | output | 1 | One-cycle pulse with a new result |
| timeout_o | output | 1 | One-cycle pulse when busy never fell |

## Verification
The bench goes after the mode changeovers. The most important one is a fast-mode request that arrives while the strobe idles low after a sleep-mode sample. A design without the wake step would never make a falling edge, so busy would never rise, and the timeout would fire in place of a result. It also sends words with ones in the four leading positions, which catches a capture that is off by one bit or that keeps the leading bits. Requests arriving while busy is awaited and during the quiet window would cause a second strobe fall in a design that does not gate them. A converter that never drops busy checks that the abort path makes no serial clocks and no valid.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int SCLK_HALF  = 2,
  parameter int STROBE_LOW = 3,
  parameter int WAKE_CYC   = 300,
  parameter int QUIET_CYC  = 20,
  parameter int TMO_W      = 12
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             sleep_mode_i,
  input  logic [TMO_W-1:0] timeout_lim_i,
  input  logic             busy_i,
  input  logic             sdata_i,
  output logic             convst_n_o,
  output logic             sclk_o,
  output logic [11:0]      data_o,
  output logic             valid_o,
  output logic             timeout_o
);
  localparam int C1 = $clog2(WAKE_CYC + 1);
  localparam int C2 = $clog2(QUIET_CYC + 1);
  localparam int C3 = $clog2(SCLK_HALF + 1);
  localparam int C4 = $clog2(STROBE_LOW + 1);
  localparam int CA = (C1 > C2) ? C1 : C2;
  localparam int CB = (C3 > C4) ? C3 : C4;
  localparam int CC = (CA > CB) ? CA : CB;
  localparam int CW = ((CC > TMO_W) ? CC : TMO_W) + 1;

  typedef enum logic [2:0] {S_IDLE, S_WAKE, S_PULSE, S_WAIT, S_READ, S_QUIET} st_t;

  st_t          state;
  logic [CW-1:0] cnt;
  logic [3:0]   bitn;
  logic [10:0]  sh;
  logic         cs_q, sck_q, valid_q, err_q, busy_q, mode_q;
  logic [11:0]  data_q;

  wire busy_fell = busy_q & ~busy_i;

  assign convst_n_o = cs_q;
  assign sclk_o     = sck_q;
  assign data_o     = data_q;
  assign valid_o    = valid_q;
  assign timeout_o  = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      sh      <= '0;
      cs_q    <= 1'b1;
      sck_q   <= 1'b0;
      data_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      busy_q  <= 1'b0;
      mode_q  <= 1'b0;
    end else begin
      busy_q  <= busy_i;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      unique case (state)
        S_IDLE: if (start_i) begin
          mode_q <= sleep_mode_i;
          cnt    <= '0;
          if (sleep_mode_i || !cs_q) begin
            cs_q  <= 1'b1;
            state <= S_WAKE;
          end else begin
            cs_q  <= 1'b0;
            state <= S_PULSE;
          end
        end
        S_WAKE: if (cnt == CW'(WAKE_CYC - 1)) begin
          cs_q  <= 1'b0;
          cnt   <= '0;
          state <= mode_q ? S_WAIT : S_PULSE;
        end else cnt <= cnt + 1'b1;
        S_PULSE: if (cnt == CW'(STROBE_LOW - 1)) begin
          cs_q  <= 1'b1;
          cnt   <= '0;
          state <= S_WAIT;
        end else cnt <= cnt + 1'b1;
        S_WAIT: if (busy_fell) begin
          state <= S_READ;
          cnt   <= '0;
          bitn  <= '0;
          sck_q <= 1'b1;
        end else if (cnt == CW'(timeout_lim_i)) begin
          err_q <= 1'b1;
          cnt   <= '0;
          state <= S_QUIET;
        end else cnt <= cnt + 1'b1;
        S_READ: if (cnt == CW'(SCLK_HALF - 1)) begin
          cnt <= '0;
          if (sck_q) begin
            sck_q <= 1'b0;
            sh    <= {sh[9:0], sdata_i};
            if (bitn == 4'd15) begin
              data_q  <= {sh, sdata_i};
              valid_q <= 1'b1;
              state   <= S_QUIET;
            end else bitn <= bitn + 1'b1;
          end else sck_q <= 1'b1;
        end else cnt <= cnt + 1'b1;
        S_QUIET: if (cnt == CW'(QUIET_CYC - 1)) state <= S_IDLE;
                 else cnt <= cnt + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_fast_high_in_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_READ && !mode_q) |-> convst_n_o);
  assert_sleep_low_in_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_READ && mode_q) |-> !convst_n_o);
  assert_clock_after_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && busy_q && !busy_i) |=> sclk_o);
  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  assert_quiet_no_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_QUIET) |=> !$fell(convst_n_o));
  assert_abort_no_clock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (!sclk_o && !valid_o));
  assert_abort_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);
endmodule

// File: tb/test_adc_seq.sv
module test_adc_seq;
  localparam int HALF = 2, LOWC = 3, WAKE = 300, QUIET = 20, TW = 12, CONV = 40;

  logic clk = 0, rst_n = 0, start_i = 0, sleep_i = 0, busy = 0, sdat = 0;
  logic [TW-1:0] tlim = 12'd100;
  logic cs_n, sck, vld, terr;
  logic [11:0] dat;
  int tests = 0, fails = 0, nval = 0, nsck = 0;
  bit done = 0;

  always #10 clk = ~clk;

  adc_seq #(.SCLK_HALF(HALF), .STROBE_LOW(LOWC), .WAKE_CYC(WAKE), .QUIET_CYC(QUIET), .TMO_W(TW))
  i_adc_seq (.clk(clk), .rst_n(rst_n), .start_i(start_i), .sleep_mode_i(sleep_i),
    .timeout_lim_i(tlim), .busy_i(busy), .sdata_i(sdat), .convst_n_o(cs_n),
    .sclk_o(sck), .data_o(dat), .valid_o(vld), .timeout_o(terr));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // converter model
  bit dev_hang = 0;
  logic [15:0] dev_word = 16'h0;
  int cc = 0, k = 0;
  logic cs_p = 1, sk_p = 0;
  always @(negedge clk) begin
    if (cs_p && !cs_n) begin busy = 1; cc = CONV; end
    else if (busy) begin
      if (cc > 0) cc--;
      if (cc == 0 && !dev_hang) begin busy = 0; k = 0; end
    end
    if (sck && !sk_p) begin
      sdat = dev_word[15-k];
      if (k < 15) k++;
      nsck++;
    end
    if (vld) nval++;
    cs_p = cs_n; sk_p = sck;
  end

  // behavioural reference: 0 idle 1 wake 2 pulse 3 wait 4 read 5 quiet
  int ph = 0, n = 0, bits = 0;
  bit msl = 0, pb = 0, e_cs = 1, e_sck = 0, e_val = 0, e_err = 0;
  logic [15:0] msh = 0;
  logic [11:0] e_dat = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; n = 0; pb = 0; e_cs = 1; e_sck = 0; e_val = 0; e_err = 0; e_dat = 0; msl = 0;
    end else begin
      e_val = 0; e_err = 0;
      case (ph)
        0: if (start_i) begin
             msl = sleep_i; n = 0;
             if (msl || !e_cs) begin ph = 1; e_cs = 1; end
             else begin ph = 2; e_cs = 0; end
           end
        1: begin n++; if (n == WAKE) begin e_cs = 0; n = 0; ph = msl ? 3 : 2; end end
        2: begin n++; if (n == LOWC) begin e_cs = 1; n = 0; ph = 3; end end
        3: if (pb && !busy) begin ph = 4; n = 0; bits = 0; e_sck = 1; end
           else if (n == int'(tlim)) begin e_err = 1; n = 0; ph = 5; end
           else n++;
        4: begin
             n++;
             if (n == HALF) begin
               n = 0;
               if (e_sck) begin
                 e_sck = 0; msh = {msh[14:0], sdat}; bits++;
                 if (bits == 16) begin e_dat = msh[11:0]; e_val = 1; ph = 5; end
               end else e_sck = 1;
             end
           end
        default: begin n++; if (n == QUIET) ph = 0; end
      endcase
      pb = busy;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk(cs_n === e_cs, "R2 strobe", cs_n, e_cs);
    chk(sck === e_sck, "R4 sclk", sck, e_sck);
    chk(vld === e_val, "R6 valid", vld, e_val);
    chk(terr === e_err, "R9 timeout", terr, e_err);
    chk(dat === e_dat, "R5 data", dat, e_dat);
  end

  task automatic run(input bit sl, input logic [15:0] w, output bit gv, output bit ge);
    dev_word = w; sleep_i = sl; start_i = 1;
    @(negedge clk); start_i = 0;
    gv = 0; ge = 0;
    for (int i = 0; i < 3000 && !gv && !ge; i++) begin
      @(negedge clk); gv = vld; ge = terr;
    end
  endtask

  task automatic idle_wait();
    repeat (QUIET + 3) @(negedge clk);
  endtask

  initial begin
    bit gv, ge;
    int v0, s0;
    repeat (4) @(negedge clk);
    chk({cs_n, sck, vld, terr} === 4'b1000, "R1", {cs_n, sck, vld, terr}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    chk({cs_n, sck, vld, terr} === 4'b1000, "R1", {cs_n, sck, vld, terr}, 4'b1000);

    s0 = nsck;
    run(0, 16'h0A5C, gv, ge);
    chk(gv && dat === 12'hA5C, "R5", dat, 12'hA5C);
    chk(cs_n === 1'b1, "R2", cs_n, 1);
    chk(nsck - s0 == 16, "R4", nsck - s0, 16);
    idle_wait();
    chk(dat === 12'hA5C, "R6", dat, 12'hA5C);

    run(0, 16'hF3C1, gv, ge);
    chk(gv && dat === 12'h3C1, "R5", dat, 12'h3C1);
    start_i = 1; @(negedge clk); start_i = 0;
    repeat (5) @(negedge clk);
    chk(cs_n === 1'b1, "R7", cs_n, 1);
    idle_wait();

    run(1, 16'h0FFF, gv, ge);
    chk(gv && dat === 12'hFFF, "R5", dat, 12'hFFF);
    chk(cs_n === 1'b0, "R3", cs_n, 0);
    idle_wait();
    chk(cs_n === 1'b0, "R3", cs_n, 0);

    run(0, 16'h5801, gv, ge);
    chk(gv && dat === 12'h801, "R3", dat, 12'h801);
    chk(cs_n === 1'b1, "R3", cs_n, 1);
    idle_wait();

    v0 = nval;
    dev_word = 16'h0246; sleep_i = 0; start_i = 1;
    @(negedge clk); start_i = 0; sleep_i = 1;
    repeat (10) @(negedge clk);
    start_i = 1; @(negedge clk); start_i = 0;
    repeat (200) @(negedge clk);
    chk(nval - v0 == 1, "R8", nval - v0, 1);
    chk(dat === 12'h246, "R10", dat, 12'h246);
    chk(cs_n === 1'b1, "R10", cs_n, 1);
    sleep_i = 0;
    idle_wait();

    tlim = 12'd10; dev_hang = 1;
    v0 = nval; s0 = nsck;
    run(0, 16'h0123, gv, ge);
    chk(ge && !gv, "R9", {gv, ge}, 2'b01);
    repeat (3) @(negedge clk);
    chk(nval == v0 && nsck == s0, "R9", nsck - s0, 0);
    dev_hang = 0; tlim = 12'd100;
    repeat (CONV + QUIET) @(negedge clk);

    run(0, 16'hC7E5, gv, ge);
    chk(gv && dat === 12'h7E5, "R5", dat, 12'h7E5);
    idle_wait();

    done = 1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; tests++; fails++;
      $display("FAIL watchdog: got hang expected finish");
      summary();
    end
  end
endmodule